// File: doc/BRIEF.md
# Overlapped Scan Test Sequencer

This block runs a complete scan test on one multiplexed-scan chain of `NSFF` flip-flops. It drives the chain's mode select, serial input and primary-input bus, and watches the chain's serial output and the primary-output bus. A run starts with a chain integrity phase: a repeating two-zeros, two-ones stream is pushed through the chain. Then it applies up to `DEPTH` combinational vectors held in a small internal vector store. Every vector holds primary-input bits, the state to load into the chain, the expected primary outputs and the expected captured state.

Each vector is loaded with `NSFF` shift clocks and then applied with one capture clock. The captured state of a vector comes out of the chain on the same clocks that load the next vector, so only the last response needs a separate unload. All compares happen on chip. Any mismatch sets a sticky fail flag. A cycle counter gives the exact length of the run, which is `(n+2)*NSFF + n + 4` clocks for `n` vectors.

The test harness writes the vector store while the block is idle, sets the vector count and pulses `start`. It then waits for `done` and reads `fail` and `cycle_cnt`.

Top module: `scan_seq_top`

## Requirements
- R1: After reset `busy`, `done` and `fail` are 0, `cycle_cnt` is 0, and `test_ctl` is 1 (normal mode) with `scan_in` 0 and `pi_bus` 0.
- R2: The first `NSFF+4` clocks after a start hold `test_ctl` at 0, and on the i-th of them (i from 0) `scan_in` equals bit 1 of i, giving the stream 0,0,1,1,0,0,...
- R3: During that integrity phase, on clock i with i >= `NSFF`, `scan_out` is compared with the value driven on clock i-`NSFF`.
- R4: Each vector is loaded in `NSFF` clocks with `test_ctl` 0, sending state bit `NSFF-1` first and bit 0 last, while `pi_bus` stays 0 on every shift clock.
- R5: Each load is followed by exactly one clock with `test_ctl` 1, during which `pi_bus` carries the vector's input bits and `po_bus` is compared with the vector's expected outputs.
- R6: The captured state of vector k is compared on `scan_out`, expected-state bit `NSFF-1` first, during the load of vector k+1. After the last capture, `NSFF` unload clocks with `scan_in` 0 compare the last response. No serial compare happens while the first vector loads.
- R7: A run of n vectors (a count of 0 is run as 1) lasts `(n+2)*NSFF + n + 4` clocks. `done` rises on the clock after the last unload clock, and `cycle_cnt` then holds that length until the next start. A start clears `done` and `cycle_cnt`.
- R8: A mismatch on any compared serial or output bit sets `fail`. It stays set until the next accepted start clears it.
- R9: A vector store word has the input bits in `[NPI-1:0]`, the load state in the next `NSFF` bits, the expected outputs in the next `NPO` bits and the expected captured state in the top `NSFF` bits. Vector k sits at address k.
- R10: `start` has no effect while a run is in progress. The run's length, vector count and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| num_vec | input | AW+1 | Number of vectors to apply, sampled at start |
| mem_we | input | 1 | Vector store write enable |
| mem_addr | input | AW | Vector store write address |
| mem_wdata | input | 2*NSFF+NPO+NPI | Vector store write word |
| test_ctl | output | 1 | Chain mode: 0 shift, 1 normal/capture |
| scan_in | output | 1 | Serial data into the chain |
| pi_bus | output | NPI | Primary inputs of the circuit under test |
| scan_out | input | 1 | Serial data from the chain |
| po_bus | input | NPO | Primary outputs of the circuit under test |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| cycle_cnt | output | CW | Clocks used by the current or last run |

## Verification
The hardest case to reach is a mismatch that shows up only at one point of the overlapped schedule. Examples are a wrong bit in the first response, which is unloaded while the second vector loads, a wrong bit in the last response, which only the final unload sees, and a chain fault that only the integrity phase sees. The bench reaches each one on its own. It corrupts the expected captured state of only the first or only the last stored vector. Separately, it inverts the chain's serial output on only the four compared integrity clocks through its stand-in chain. Each of these must set `fail`, and a clean rerun must clear it again.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_LOAD,
    PH_CAPT,
    PH_FLUSH
  } phase_t;
endpackage

// File: rtl/scan_vec_mem.sv
module scan_vec_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp #(
  parameter int NPO = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           so_en,
  input  logic           so_exp,
  input  logic           so_act,
  input  logic           po_en,
  input  logic [NPO-1:0] po_exp,
  input  logic [NPO-1:0] po_act,
  output logic           fail
);
  logic fail_q, fail_d, miss;

  always_comb begin
    miss   = (so_en && (so_exp != so_act)) || (po_en && (po_exp != po_act));
    fail_d = clr ? 1'b0 : (fail_q | miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  assign fail = fail_q;

  // R8: once set, the flag holds until a start clears it
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !clr |=> fail_q);
  // R8: an output mismatch sets the flag on the next clock
  a_r8_po_miss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    po_en && (po_act != po_exp) && !clr |=> fail_q);
  // R3, R6: a serial mismatch sets the flag on the next clock
  a_r6_so_miss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    so_en && (so_act != so_exp) && !clr |=> fail_q);
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 8,
  parameter int NPI   = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(NSFF + 5)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW:0]     num_vec,
  input  logic [NPI-1:0]  ent_pi,
  input  logic [NSFF-1:0] ent_st,
  input  logic [NSFF-1:0] ent_ns,
  output logic [AW-1:0]   rd_addr,
  output logic            tc,
  output logic            si,
  output logic [NPI-1:0]  pi_out,
  output logic            so_en,
  output logic            so_exp,
  output logic            po_en,
  output logic            clr,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   cycle_cnt
);
  phase_t          phase_q, phase_d;
  logic [BW-1:0]   bcnt_q, bcnt_d, rev;
  logic [AW-1:0]   vidx_q, vidx_d;
  logic [AW:0]     nvec_q, nvec_d;
  logic [NSFF-1:0] prev_q;
  logic [CW-1:0]   cyc_q;
  logic            done_q, done_d;
  logic            pre_last, sh_last, vec_last, st_bit, ns_bit, pre_bit;

  assign pre_last = (bcnt_q == BW'(NSFF + 3));
  assign sh_last  = (bcnt_q == BW'(NSFF - 1));
  assign vec_last = ({1'b0, vidx_q} == (nvec_q - 1'b1));
  assign rev      = BW'(NSFF - 1) - bcnt_q;
  assign pre_bit  = |((bcnt_q - BW'(NSFF)) & BW'(2));

  // bit pick of the load state and of the previous response, MSB first
  always_comb begin
    st_bit = 1'b0;
    ns_bit = 1'b0;
    for (int b = 0; b < NSFF; b++) begin
      if (rev == BW'(b)) begin
        st_bit = ent_st[b];
        ns_bit = prev_q[b];
      end
    end
  end

  always_comb begin
    phase_d = phase_q;
    bcnt_d  = bcnt_q;
    vidx_d  = vidx_q;
    nvec_d  = nvec_q;
    done_d  = done_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_PRE;
        bcnt_d  = '0;
        vidx_d  = '0;
        nvec_d  = (num_vec == '0) ? (AW+1)'(1) : num_vec;
        done_d  = 1'b0;
      end
      PH_PRE: begin
        bcnt_d = pre_last ? '0 : bcnt_q + 1'b1;
        if (pre_last) phase_d = PH_LOAD;
      end
      PH_LOAD: begin
        bcnt_d = sh_last ? '0 : bcnt_q + 1'b1;
        if (sh_last) phase_d = PH_CAPT;
      end
      PH_CAPT: begin
        bcnt_d = '0;
        if (vec_last) phase_d = PH_FLUSH;
        else begin
          phase_d = PH_LOAD;
          vidx_d  = vidx_q + 1'b1;
        end
      end
      PH_FLUSH: begin
        bcnt_d = sh_last ? '0 : bcnt_q + 1'b1;
        if (sh_last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bcnt_q  <= '0;
      vidx_q  <= '0;
      nvec_q  <= '0;
      prev_q  <= '0;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bcnt_q  <= bcnt_d;
      vidx_q  <= vidx_d;
      done_q  <= done_d;
      if (clr) nvec_q <= nvec_d;
      if (phase_q == PH_CAPT) prev_q <= ent_ns;
      if (clr)       cyc_q <= '0;
      else if (busy) cyc_q <= cyc_q + 1'b1;
    end
  end

  always_comb begin
    busy   = (phase_q != PH_IDLE);
    clr    = (phase_q == PH_IDLE) && start;
    tc     = (phase_q == PH_IDLE) || (phase_q == PH_CAPT);
    pi_out = (phase_q == PH_CAPT) ? ent_pi : '0;
    po_en  = (phase_q == PH_CAPT);
    si     = 1'b0;
    so_en  = 1'b0;
    so_exp = 1'b0;
    case (phase_q)
      PH_PRE: begin
        si     = |(bcnt_q & BW'(2));
        so_en  = (bcnt_q >= BW'(NSFF));
        so_exp = pre_bit;
      end
      PH_LOAD: begin
        si     = st_bit;
        so_en  = (vidx_q != '0);
        so_exp = ns_bit;
      end
      PH_FLUSH: begin
        so_en  = 1'b1;
        so_exp = ns_bit;
      end
      default: ;
    endcase
  end

  assign rd_addr   = vidx_q;
  assign done      = done_q;
  assign cycle_cnt = cyc_q;

  logic [CW-1:0] len_exp;
  assign len_exp = CW'((int'(nvec_q) + 2) * NSFF + int'(nvec_q) + 4);

  // R7: the finished run has the closed-form length
  a_r7_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> cyc_q == len_exp);
  // R5: a capture clock is always followed by a shift clock
  a_r5_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tc |=> !tc);
  // R4: primary inputs stay quiet on shift clocks
  a_r4_pi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tc |-> pi_out == '0);
  // R10: a start during a run leaves the vector count alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(nvec_q));
  // R7: the count holds while idle
  a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cyc_q));
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int NSFF  = 8,
  parameter int NPI   = 4,
  parameter int NPO   = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = 2 * NSFF + NPO + NPI
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW:0]    num_vec,
  input  logic           mem_we,
  input  logic [AW-1:0]  mem_addr,
  input  logic [W-1:0]   mem_wdata,
  output logic           test_ctl,
  output logic           scan_in,
  output logic [NPI-1:0] pi_bus,
  input  logic           scan_out,
  input  logic [NPO-1:0] po_bus,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic [CW-1:0]  cycle_cnt
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic [AW-1:0]   rd_addr;
  logic [W-1:0]    ent;
  logic            so_en, so_exp, po_en, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  scan_vec_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(ent)
  );

  scan_seq_ctrl #(.NSFF(NSFF), .NPI(NPI), .DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .num_vec(num_vec),
    .ent_pi(ent[NPI-1:0]),
    .ent_st(ent[NPI +: NSFF]),
    .ent_ns(ent[W-1 -: NSFF]),
    .rd_addr(rd_addr), .tc(test_ctl), .si(scan_in), .pi_out(pi_bus),
    .so_en(so_en), .so_exp(so_exp), .po_en(po_en), .clr(clr),
    .busy(busy), .done(done), .cycle_cnt(cycle_cnt)
  );

  scan_resp_cmp #(.NPO(NPO)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .clr(clr),
    .so_en(so_en), .so_exp(so_exp), .so_act(scan_out),
    .po_en(po_en), .po_exp(ent[NPI+NSFF +: NPO]), .po_act(po_bus),
    .fail(fail)
  );

  // R1: idle outputs hold the circuit in normal mode
  a_r1_idle_normal: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> test_ctl && !scan_in && (pi_bus == '0));
  // R7: done and busy are never both set
  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done && busy));
endmodule

// File: tb/sim_chain_model.sv
module sim_chain_model (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tc,
  input  logic       si,
  input  logic [1:0] pi,
  input  logic       flip_so,
  output logic       so,
  output logic [1:0] po
);
  logic [3:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 4'b0000;
    else if (tc) q <= {q[2:0], q[3]} ^ {pi, pi};
    else         q <= {q[2:0], si};
  end
  assign so = q[3] ^ flip_so;
  assign po = q[1:0] ^ pi;
endmodule

// File: tb/sim_scan_seq_top.sv
module sim_scan_seq_top;
  localparam int N  = 4;
  localparam int NP = 2;
  localparam int D  = 8;
  localparam int AW = 3;
  localparam int W  = 2 * N + 2 + NP;

  // table of {pi, load state}; expectations are derived below
  localparam logic [5:0] VTAB [8] = '{6'b01_1010, 6'b10_0111, 6'b11_0000,
    6'b00_1111, 6'b01_0101, 6'b10_1001, 6'b11_1110, 6'b00_0011};

  logic clk = 1'b0;
  logic rst_n, start, mem_we, flip_so;
  logic [AW:0] num_vec;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata;
  logic tc, si, so, busy, done, fail;
  logic [1:0] pi_bus, po_bus;
  logic [31:0] cycle_cnt;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scan_seq_top #(.NSFF(N), .NPI(NP), .NPO(2), .DEPTH(D), .CW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_vec(num_vec),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .test_ctl(tc), .scan_in(si), .pi_bus(pi_bus), .scan_out(so),
    .po_bus(po_bus), .busy(busy), .done(done), .fail(fail),
    .cycle_cnt(cycle_cnt)
  );

  sim_chain_model u_chain (
    .clk(clk), .rst_n(rst_n), .tc(tc), .si(si), .pi(pi_bus),
    .flip_so(flip_so), .so(so), .po(po_bus)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] f_po(input logic [5:0] v);
    return v[1:0] ^ v[5:4];
  endfunction
  function automatic logic [3:0] f_ns(input logic [5:0] v);
    return {v[2:0], v[3]} ^ {v[5:4], v[5:4]};
  endfunction

  // R9 word layout: {exp_ns, exp_po, state, pi}
  task automatic wr_vec(input int k, input logic [1:0] po_x, input logic [3:0] ns_x);
    mem_we = 1'b1;
    mem_addr = AW'(k);
    mem_wdata = {f_ns(VTAB[k]) ^ ns_x, f_po(VTAB[k]) ^ po_x, VTAB[k][3:0], VTAB[k][5:4]};
    step();
    mem_we = 1'b0;
  endtask

  task automatic run(input int n, input bit trace, input bit flip_pre,
                     input bit poke);
    int ne = (n == 0) ? 1 : n;
    int len = (ne + 2) * N + ne + 4;
    num_vec = (AW+1)'(n);
    start = 1'b1;
    step();
    start = 1'b0;
    chk(done == 1'b0 && fail == 1'b0, "R7 start clears done/fail", {done, fail}, 0);
    for (int t = 0; t < len; t++) begin
      flip_so = flip_pre && (t >= N) && (t < N + 4);
      start = poke && (t == 6);
      if (trace) begin
        logic etc, esi;
        logic [1:0] epi;
        etc = 1'b0; esi = 1'b0; epi = 2'b00;
        if (t < N + 4) esi = t[1];
        else if (t < N + 4 + ne * (N + 1)) begin
          int u = t - (N + 4);
          int v = u / (N + 1);
          int j = u % (N + 1);
          if (j == N) begin etc = 1'b1; epi = VTAB[v][5:4]; end
          else esi = VTAB[v][3 - j];
        end
        if (t < N + 4) chk(tc == etc && si == esi && pi_bus == epi,
          "R2 preamble drive", {tc, si, pi_bus}, {etc, esi, epi});
        else if (etc) chk(tc == etc && pi_bus == epi,
          "R5 capture drive", {tc, pi_bus}, {etc, epi});
        else chk(tc == etc && si == esi && pi_bus == epi,
          "R4 R6 shift drive", {tc, si, pi_bus}, {etc, esi, epi});
      end
      step();
    end
    flip_so = 1'b0;
    start = 1'b0;
    chk(done && !busy, "R7 done after unload", {done, busy}, 2'b10);
    chk(cycle_cnt == 32'(len), "R7 cycle count", cycle_cnt, 32'(len));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_we = 1'b0; flip_so = 1'b0;
    num_vec = '0; mem_addr = '0; mem_wdata = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    // R1 reset state
    chk(!busy && !done && !fail && cycle_cnt == 0, "R1 reset flags",
        {busy, done, fail, cycle_cnt[0]}, 0);
    chk(tc && !si && pi_bus == 0, "R1 idle drive", {tc, si, pi_bus}, 4'b1000);

    for (int k = 0; k < D; k++) wr_vec(k, 2'b00, 4'b0000);

    // R2 R4 R5 R6 R9: traced run of five good vectors
    run(5, 1'b1, 1'b0, 1'b0);
    chk(!fail, "R6 R9 good run passes", fail, 0);
    step(); step();
    chk(done && cycle_cnt == 32'(7 * N + 9), "R7 result holds", cycle_cnt, 7 * N + 9);

    // R5 R8: wrong expected outputs on vector 2
    wr_vec(2, 2'b01, 4'b0000);
    run(5, 1'b0, 1'b0, 1'b0);
    chk(fail, "R5 R8 output mismatch flagged", fail, 1);
    wr_vec(2, 2'b00, 4'b0000);
    run(5, 1'b0, 1'b0, 1'b0);
    chk(!fail, "R8 start clears fail", fail, 0);

    // R6: first response, seen during the load of vector 1
    wr_vec(0, 2'b00, 4'b1000);
    run(5, 1'b0, 1'b0, 1'b0);
    chk(fail, "R6 overlap unload mismatch", fail, 1);
    wr_vec(0, 2'b00, 4'b0000);

    // R6: last response, seen only in the final unload
    wr_vec(4, 2'b00, 4'b0001);
    run(5, 1'b0, 1'b0, 1'b0);
    chk(fail, "R6 final unload mismatch", fail, 1);
    run(4, 1'b0, 1'b0, 1'b0);
    chk(!fail, "R6 corrupt entry unused", fail, 0);
    wr_vec(4, 2'b00, 4'b0000);

    // R3: chain fault visible only in the integrity phase
    run(3, 1'b0, 1'b1, 1'b0);
    chk(fail, "R3 preamble compare", fail, 1);

    // R7 boundaries: one vector, zero (run as one), full store
    run(1, 1'b1, 1'b0, 1'b0);
    chk(!fail, "R7 single vector passes", fail, 0);
    run(0, 1'b0, 1'b0, 1'b0);
    chk(!fail, "R7 zero count passes", fail, 0);
    run(8, 1'b1, 1'b0, 1'b0);
    chk(!fail, "R7 full store passes", fail, 0);

    // R10: start pulse during a run is ignored
    run(3, 1'b1, 1'b0, 1'b1);
    chk(!fail, "R10 run unaffected", fail, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule